// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the receiving end of a two-wire serial management link. It takes raw clock (MDC) and data (MDIO) levels, for example levels written by software into a bit-banged control register, and resynchronises them into the system clock domain. From the edges it finds it decodes a standard management frame. The frame carries a long run of ones, a start marker, a two-bit opcode, a five-bit device address, a five-bit register address, a two-period turnaround and sixteen data bits.

For a read it fetches a sixteen-bit value from the attached register file and returns it on the data line. For a write it collects the sixteen bits and issues a single-cycle write strobe when the frame ends. Only one device address counts as present. It is set by a parameter and defaults to 1. A read from any other address returns all ones, and a write to it is dropped. The block supplies the output data value and a drive-enable signal. The pad tristate is left to the chip.

Top module: `mdio_frame_slave`

## Requirements
- R1: After reset the drive enable, the write strobe, the read request and the start warning are all low.
- R2: A frame is accepted only after at least 32 consecutive MDC rising edges with MDIO sampled high, followed by a rising edge with MDIO low. A low sample before the 32nd high sample restarts the count, so a frame with 31 preamble ones has no effect. Any preamble longer than 32 is accepted.
- R3: The rising edge after the preamble is the start bit and is expected high. If it is sampled low, start_warn_o pulses for one cycle and the frame still completes.
- R4: On rising edges the block shifts in, MSB first, 2 opcode bits, then 5 device-address bits, then 5 register-address bits. The register address is presented on reg_addr_o until the next frame captures a new one.
- R5: Turnaround lasts 2 rising edges. On the second of them, opcode 2'b10 selects a read and the drive enable rises. If the device is present, rd_req_o is high for exactly that one cycle and rd_data_i is captured in that cycle.
- R6: During a read, mdio_o changes only on MDC falling edges. It delivers the 16 data bits MSB first, one per data period, so the master can sample them on the following rising edges.
- R7: A read addressed to an absent device returns 16'hFFFF and raises no read request.
- R8: Any opcode other than 2'b10 is a write. The 16 data bits are sampled on rising edges MSB first. On the 16th data rising edge, wr_stb_o pulses for one cycle, with wr_data_o holding the word and reg_addr_o holding the register.
- R9: The 16th data rising edge returns the block to preamble hunting and releases the drive enable. A following frame needs a fresh preamble of at least 32 ones.
- R10: A device counts as present only when the address field equals PHY_ADDR (default 1). A write to any other address produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management clock level, asynchronous |
| mdio_i | input | 1 | Management data level from the master, asynchronous |
| mdio_o | output | 1 | Data value driven back during a read |
| mdio_oe_o | output | 1 | Drive enable for the data line |
| reg_addr_o | output | 5 | Register address captured from the frame |
| rd_req_o | output | 1 | One-cycle read fetch for a present device |
| rd_data_i | input | 16 | Register value returned in the rd_req_o cycle |
| wr_stb_o | output | 1 | One-cycle write strobe at the end of a write frame |
| wr_data_o | output | 16 | Data word collected from a write frame |
| start_warn_o | output | 1 | One-cycle pulse when the start bit is sampled low |

## Verification
The frames are tried with preambles of exactly 32, 31, 45 and zero ones. This separates the acceptance threshold from counting that never restarts. Reads and writes go to the present address and to absent ones, and each write is checked by reading it back. This tells a strobe that is missing or misdirected apart from a fetch that is wrong. A low start bit shows that the warning is raised and that the frame still completes. Random frames with mixed opcodes, addresses and data then test the MSB-first field order against a bench register model.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
   localparam int OP_W = 2;
   localparam logic [OP_W-1:0] OP_READ = 2'b10;

   typedef enum logic [2:0] {
      S_PRE   = 3'd0,
      S_START = 3'd1,
      S_OP    = 3'd2,
      S_DEV   = 3'd3,
      S_REG   = 3'd4,
      S_TA    = 3'd5,
      S_DATA  = 3'd6
   } frame_state_t;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc_i,
   input  logic mdio_i,
   output logic rise_o,
   output logic fall_o,
   output logic bit_o
);
   logic [STAGES-1:0] mdc_q;
   logic [STAGES-1:0] dat_q;
   logic              mdc_prev;

   initial begin
      if (STAGES < 2) $error("STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q[0] <= 1'b0;
         dat_q[0] <= 1'b0;
      end else begin
         mdc_q[0] <= mdc_i;
         dat_q[0] <= mdio_i;
      end
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mdc_q[g] <= 1'b0;
            dat_q[g] <= 1'b0;
         end else begin
            mdc_q[g] <= mdc_q[g-1];
            dat_q[g] <= dat_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdc_prev <= 1'b0;
      else        mdc_prev <= mdc_q[STAGES-1];
   end

   assign rise_o = mdc_q[STAGES-1] & ~mdc_prev;
   assign fall_o = ~mdc_q[STAGES-1] & mdc_prev;
   assign bit_o  = dat_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
   import mdio_frame_pkg::*;
#(
   parameter int PRE_LEN  = 32,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int PHY_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              bit_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              rd_req_o,
   output logic              wr_stb_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              start_warn_o,
   output logic              oe_o,
   output logic              load_o,
   output logic [DATA_W-1:0] load_val_o
);
   localparam int CNT_MAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   frame_state_t      state;
   logic [CNT_W-1:0]  cnt;
   logic [OP_W-1:0]   op_q;
   logic [ADDR_W-1:0] dev_q;
   logic [ADDR_W-1:0] reg_q;
   logic [DATA_W-1:0] rx_q;
   logic              present;
   logic              is_read;
   logic              ta_end;

   initial begin
      if (PHY_ADDR < 0 || PHY_ADDR >= (1 << ADDR_W)) $error("PHY_ADDR out of range");
      if (PRE_LEN < 1) $error("PRE_LEN must be positive");
   end

   assign present    = (dev_q == ADDR_W'(PHY_ADDR));
   assign is_read    = (op_q == OP_READ);
   assign ta_end     = rise_i && (state == S_TA) && (cnt == CNT_W'(1));
   assign rd_req_o   = ta_end && is_read && present;
   assign load_o     = ta_end && is_read;
   assign load_val_o = present ? rd_data_i : '1;
   assign reg_addr_o = reg_q;
   assign wr_data_o  = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= S_PRE;
         cnt          <= '0;
         op_q         <= '0;
         dev_q        <= '0;
         reg_q        <= '0;
         rx_q         <= '0;
         oe_o         <= 1'b0;
         wr_stb_o     <= 1'b0;
         start_warn_o <= 1'b0;
      end else begin
         wr_stb_o     <= 1'b0;
         start_warn_o <= 1'b0;
         if (rise_i) begin
            case (state)
               S_PRE: begin
                  if (bit_i) begin
                     if (cnt < CNT_W'(PRE_LEN)) cnt <= cnt + 1'b1;
                  end else if (cnt >= CNT_W'(PRE_LEN)) begin
                     state <= S_START;
                     cnt   <= '0;
                  end else begin
                     cnt <= '0;
                  end
               end
               S_START: begin
                  start_warn_o <= ~bit_i;
                  state        <= S_OP;
                  cnt          <= '0;
               end
               S_OP: begin
                  op_q <= {op_q[OP_W-2:0], bit_i};
                  if (cnt == CNT_W'(OP_W - 1)) begin
                     state <= S_DEV;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               S_DEV: begin
                  dev_q <= {dev_q[ADDR_W-2:0], bit_i};
                  if (cnt == CNT_W'(ADDR_W - 1)) begin
                     state <= S_REG;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               S_REG: begin
                  reg_q <= {reg_q[ADDR_W-2:0], bit_i};
                  if (cnt == CNT_W'(ADDR_W - 1)) begin
                     state <= S_TA;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               S_TA: begin
                  if (cnt == CNT_W'(1)) begin
                     state <= S_DATA;
                     cnt   <= '0;
                     oe_o  <= is_read;
                  end else cnt <= cnt + 1'b1;
               end
               S_DATA: begin
                  if (!oe_o) rx_q <= {rx_q[DATA_W-2:0], bit_i};
                  if (cnt == CNT_W'(DATA_W - 1)) begin
                     state    <= S_PRE;
                     cnt      <= '0;
                     oe_o     <= 1'b0;
                     wr_stb_o <= !oe_o && present;
                  end else cnt <= cnt + 1'b1;
               end
               default: begin
                  state <= S_PRE;
                  cnt   <= '0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_val_i,
   input  logic              shift_i,
   output logic              mdio_o
);
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         mdio_o <= 1'b0;
      end else if (load_i) begin
         sh_q   <= load_val_i;
         mdio_o <= 1'b0;
      end else if (shift_i) begin
         mdio_o <= sh_q[DATA_W-1];
         sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/mdio_frame_slave.sv
module mdio_frame_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_LEN     = 32,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 16,
   parameter int PHY_ADDR    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc_i,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              rd_req_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_stb_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              start_warn_o
);
   logic              mdc_rise;
   logic              mdc_fall;
   logic              mdio_bit;
   logic              tx_load;
   logic [DATA_W-1:0] tx_val;

   initial begin
      if (DATA_W < 2 || ADDR_W < 2) $error("field widths too small");
   end

   mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
      .rise_o(mdc_rise), .fall_o(mdc_fall), .bit_o(mdio_bit)
   );

   mdio_frame_fsm #(
      .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHY_ADDR(PHY_ADDR)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .rise_i(mdc_rise), .bit_i(mdio_bit),
      .rd_data_i(rd_data_i), .reg_addr_o(reg_addr_o), .rd_req_o(rd_req_o),
      .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o), .start_warn_o(start_warn_o),
      .oe_o(mdio_oe_o), .load_o(tx_load), .load_val_o(tx_val)
   );

   mdio_tx_shift #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load_i(tx_load), .load_val_i(tx_val),
      .shift_i(mdc_fall & mdio_oe_o), .mdio_o(mdio_o)
   );
endmodule

// File: rtl/mdio_frame_chk.sv
module mdio_frame_chk (
   input logic clk,
   input logic rst_n,
   input logic mdio_o,
   input logic mdio_oe_o,
   input logic rd_req_o,
   input logic wr_stb_o,
   input logic start_warn_o,
   input logic mdc_fall
);
   // R8
   wr_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);

   // R9
   stb_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> !mdio_oe_o);

   // R5
   req_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> mdio_oe_o);

   // R6
   change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe_o && $past(mdio_oe_o) && !$stable(mdio_o)) |-> $past(mdc_fall));

   // R3
   warn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_warn_o |=> !start_warn_o);
endmodule

bind mdio_frame_slave mdio_frame_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
   .rd_req_o(rd_req_o), .wr_stb_o(wr_stb_o), .start_warn_o(start_warn_o),
   .mdc_fall(mdc_fall)
);

// File: tb/mdio_frame_slave_bench.sv
module mdio_frame_slave_bench;
   localparam int H = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdc = 1'b0;
   logic        mdio = 1'b1;
   logic        mdio_o, mdio_oe;
   logic [4:0]  reg_addr;
   logic        rd_req, wr_stb, warn;
   logic [15:0] rd_data, wr_data;

   logic [15:0] dev_regs [32];
   logic [15:0] ref_regs [32];
   int          wr_cnt = 0, rd_cnt = 0, warn_cnt = 0;
   logic [15:0] last_wd;
   logic [4:0]  last_wa;
   int          n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   mdio_frame_slave u_mdio_frame_slave (
      .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(mdio),
      .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .reg_addr_o(reg_addr),
      .rd_req_o(rd_req), .rd_data_i(rd_data), .wr_stb_o(wr_stb),
      .wr_data_o(wr_data), .start_warn_o(warn)
   );

   assign rd_data = dev_regs[reg_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) dev_regs[i] <= 16'h1000 + 16'(i * 37);
      end else begin
         if (wr_stb) begin
            dev_regs[reg_addr] <= wr_data;
            wr_cnt  <= wr_cnt + 1;
            last_wd <= wr_data;
            last_wa <= reg_addr;
         end
         if (rd_req) rd_cnt <= rd_cnt + 1;
         if (warn) warn_cnt <= warn_cnt + 1;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit present(logic [4:0] a);
      return a == 5'd1;
   endfunction

   function automatic logic [15:0] exp_read(logic [4:0] a, logic [4:0] r);
      return present(a) ? ref_regs[r] : 16'hFFFF;
   endfunction

   task automatic half();
      repeat (H) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      mdc = 1'b0; mdio = b; half();
      mdc = 1'b1; half();
   endtask

   task automatic frame(int pre_n, logic st, logic [1:0] op, logic [4:0] a,
                        logic [4:0] r, logic [15:0] wd,
                        output logic [15:0] rd, output bit oe_seen);
      rd = '0; oe_seen = 0;
      for (int i = 0; i < pre_n; i++) send_bit(1'b1);
      send_bit(1'b0);
      send_bit(st);
      for (int i = 1; i >= 0; i--) send_bit(op[i]);
      for (int i = 4; i >= 0; i--) send_bit(a[i]);
      for (int i = 4; i >= 0; i--) send_bit(r[i]);
      send_bit(1'b1);
      send_bit(1'b0);
      for (int i = 15; i >= 0; i--) begin
         if (op == 2'b10) begin
            mdc = 1'b0; mdio = 1'b1; half();
            rd[i] = mdio_o;
            if (mdio_oe) oe_seen = 1;
            mdc = 1'b1; half();
         end else begin
            mdc = 1'b0; mdio = wd[i]; half();
            if (mdio_oe) oe_seen = 1;
            mdc = 1'b1; half();
         end
      end
      mdc = 1'b0; mdio = 1'b1; half();
   endtask

   task automatic do_read(string tag, int pre_n, logic [4:0] a, logic [4:0] r);
      logic [15:0] v; bit oe; int rc;
      rc = rd_cnt;
      frame(pre_n, 1'b1, 2'b10, a, r, 16'h0, v, oe);
      chk({tag, " R4 R6 read data"}, 32'(v), 32'(exp_read(a, r)));
      chk({tag, " R5 drive seen"}, 32'(oe), 32'd1);
      chk({tag, " R5 R7 request count"}, 32'(rd_cnt - rc), present(a) ? 32'd1 : 32'd0);
      chk({tag, " R9 drive released"}, 32'(mdio_oe), 32'd0);
   endtask

   task automatic do_write(string tag, int pre_n, logic st, logic [1:0] op,
                           logic [4:0] a, logic [4:0] r, logic [15:0] wd, bit accept);
      logic [15:0] v; bit oe; int wc;
      wc = wr_cnt;
      frame(pre_n, st, op, a, r, wd, v, oe);
      chk({tag, " R8 R10 strobe count"}, 32'(wr_cnt - wc),
          (accept && present(a)) ? 32'd1 : 32'd0);
      chk({tag, " R8 no drive"}, 32'(oe), 32'd0);
      if (accept && present(a)) begin
         chk({tag, " R8 strobe data"}, 32'(last_wd), 32'(wd));
         chk({tag, " R4 R8 strobe reg"}, 32'(last_wa), 32'(r));
         ref_regs[r] = wd;
      end
   endtask

   initial begin
      int wn;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 32; i++) ref_regs[i] = 16'h1000 + 16'(i * 37);
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 oe", 32'(mdio_oe), 32'd0);
      chk("R1 strobe", 32'(wr_stb), 32'd0);
      chk("R1 req", 32'(rd_req), 32'd0);
      chk("R1 warn", 32'(warn), 32'd0);
      rst_n = 1'b1;
      half();

      do_read("dir R5", 32, 5'd1, 5'd2);
      do_read("dir R7 absent", 32, 5'd5, 5'd2);
      do_write("dir R8", 32, 1'b1, 2'b01, 5'd1, 5'd7, 16'hA5C3, 1);
      do_read("dir R8 readback", 32, 5'd1, 5'd7);
      do_write("dir R10 absent write", 32, 1'b1, 2'b01, 5'd0, 5'd7, 16'h0F0F, 1);
      do_read("dir R10 readback", 32, 5'd1, 5'd7);
      // R2: 31 ones is too short
      do_write("dir R2 short pre", 31, 1'b1, 2'b01, 5'd1, 5'd9, 16'h0000, 0);
      do_read("dir R2 readback", 32, 5'd1, 5'd9);
      // R2: long preamble accepted
      do_write("dir R2 long pre", 45, 1'b1, 2'b11, 5'd1, 5'd9, 16'h8001, 1);
      do_read("dir R2 long readback", 45, 5'd1, 5'd9);
      // R3: low start bit warns, frame completes
      wn = warn_cnt;
      do_write("dir R3 bad start", 32, 1'b0, 2'b01, 5'd1, 5'd3, 16'h1234, 1);
      chk("R3 warn pulses", 32'(warn_cnt - wn), 32'd1);
      do_read("dir R3 readback", 32, 5'd1, 5'd3);
      // R9: no fresh preamble after a frame
      do_write("dir R9 no pre", 0, 1'b1, 2'b01, 5'd1, 5'd4, 16'h5555, 0);
      do_read("dir R9 readback", 32, 5'd1, 5'd4);

      for (int k = 0; k < 24; k++) begin
         logic [1:0] op; logic [4:0] a, r; logic [15:0] d;
         case ($urandom % 3)
            0: op = 2'b10;
            1: op = 2'b01;
            default: op = 2'b11;
         endcase
         a = ($urandom % 2) ? 5'd1 : 5'($urandom);
         r = 5'($urandom);
         d = 16'($urandom);
         if (op == 2'b10) do_read("rnd R4", 32, a, r);
         else do_write("rnd R8", 32, 1'b1, op, a, r, d, 1);
      end
      chk("R1 warn total", 32'(warn_cnt), 32'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule